// File: doc/BRIEF.md
# Ethernet Receive Destination-Address Filter

This block decides whether an incoming Ethernet frame is kept or dropped, using only its 48-bit destination address. The receive path feeds the address bytes one per cycle in wire order, marking the first with a start-of-frame pulse. The filter collects six bytes and then gives a one-cycle verdict: an accept flag and a code that says which rule decided.

Several rules run side by side. A bank of exact-match address slots serves unicast traffic. Slot 0 is always live, and each further slot has its own enable. A 64-bit hash table serves multicast traffic. Its index comes from six bits of the Ethernet CRC-32 taken over the address. Mode bits can widen acceptance to all multicast frames, or to every frame: the promiscuous bit and a debug override both do this. Broadcast frames pass unless a disable bit is set. A plain write port loads every setting.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, no decision is valid, and all mode bits, hash words, slot addresses and slot enables are zero.
- R2: `decision_valid_o` is high for exactly one cycle. That cycle follows the clock edge that captures the sixth address byte. Bytes arriving after the sixth are ignored until the next `sof_i`.
- R3: `sof_i` discards any partial address and treats the byte presented with it as byte 0 of a new address.
- R4: Each slot k holds an address split in two. Address 16+2k holds the first two received bytes in bits 15:8 (first byte) and 7:0. Address 17+2k holds bytes 2..5, with byte 2 in bits 31:24. A unicast destination equal to an enabled slot is accepted with code 1. Slot 0 is always enabled. Slot k≥1 is enabled by bit k of register 3.
- R5: The hash index is formed as follows. Take the reflected CRC-32 (polynomial 0xEDB88320) over the six bytes, with preset all ones and the result complemented. Bit-reverse it and keep the top 6 bits. Index bit 5 selects register 2 (high word) when 1 or register 1 (low word) when 0. Bits 4..0 pick the bit within that word.
- R6: With hash mode on (register 0 bit 2), a multicast destination is accepted with code 2 only if its indexed hash bit is 1. Otherwise it is dropped with code 0. A destination is multicast when bit 0 of its first byte is 1.
- R7: With pass-all-multicast on (register 0 bit 1), every non-broadcast multicast destination is accepted with code 5, whatever the hash table holds.
- R8: With promiscuous on (register 0 bit 0), every destination is accepted with code 4.
- R9: With receive-all on (register 0 bit 3), every destination is accepted with code 4, even when broadcast is disabled.
- R10: The all-ones destination is accepted with code 3 unless broadcast-disable (register 0 bit 4) is set. In that case it is dropped with code 0, unless R8 or R9 applies.
- R11: When valid, `accept_o` is 1 exactly when `match_o` is not 0 (0 none, 1 perfect, 2 hash, 3 broadcast, 4 promiscuous, 5 all-multicast). A unicast destination with no enabled slot match is dropped with code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write address |
| wr_data_i | input | 32 | Register write data |
| sof_i | input | 1 | Start of frame, marks byte 0 |
| byte_valid_i | input | 1 | Receive byte present |
| byte_i | input | 8 | Receive byte, wire order |
| decision_valid_o | output | 1 | Verdict valid, one-cycle pulse |
| accept_o | output | 1 | Frame accepted |
| match_o | output | 3 | Rule that decided |

## Verification
On every cycle, assertions check four things. The verdict is a single-cycle pulse, and the byte count stays within six. Accept agrees with the match code. The override modes and broadcast-disable act as stated, and a restart presets the CRC. The scenarios cover what only known stimulus can show. The hash index is recomputed in the bench from a bit-serial CRC and compared against what the table selects. The scenarios also show which slot writes and enables produce exact matches, and that restarts and trailing bytes leave the verdict unchanged.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int unsigned DA_BYTES = 6;
  localparam logic [31:0] CRC_POLY = 32'hEDB88320;

  typedef enum logic [2:0] {
    MT_NONE    = 3'd0,
    MT_PERFECT = 3'd1,
    MT_HASH    = 3'd2,
    MT_BCAST   = 3'd3,
    MT_PROMISC = 3'd4,
    MT_ALLMC   = 3'd5
  } match_e;

  // Register 0 layout, msb first
  typedef struct packed {
    logic bcast_dis;
    logic rx_all;
    logic hash_mc;
    logic pass_mc;
    logic promisc;
  } mode_t;

  function automatic logic [31:0] crc_step(logic [31:0] c_in, logic [7:0] b);
    logic [31:0] c;
    c = c_in ^ {24'h0, b};
    for (int i = 0; i < 8; i++) c = c[0] ? ((c >> 1) ^ CRC_POLY) : (c >> 1);
    return c;
  endfunction
endpackage

// File: rtl/rxf_crc8.sv
module rxf_crc8
  import rxf_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       en_i,
  input  logic [7:0] byte_i,
  output logic [5:0] idx_o
);
  logic [31:0] crc_q, seed, fin;

  assign seed = clr_i ? 32'hFFFF_FFFF : crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    crc_q <= 32'hFFFF_FFFF;
    else if (en_i)  crc_q <= crc_step(seed, byte_i);
    else if (clr_i) crc_q <= 32'hFFFF_FFFF;
  end

  // complement, bit-reverse, keep top six
  assign fin = ~crc_q;
  always_comb begin
    for (int i = 0; i < 6; i++) idx_o[5-i] = fin[i];
  end

  AST_CRC_PRESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !en_i) |=> (crc_q == 32'hFFFF_FFFF)); // R3
endmodule

// File: rtl/rxf_cfg_regs.sv
module rxf_cfg_regs
  import rxf_pkg::*;
#(
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned NUM_SLOTS = 17
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    wr_addr_i,
  input  logic [31:0]          wr_data_i,
  output mode_t                mode_o,
  output logic [31:0]          hash_lo_o,
  output logic [31:0]          hash_hi_o,
  output logic [NUM_SLOTS-1:0] slot_en_o
);
  localparam int unsigned MODE_W = $bits(mode_t);

  logic [NUM_SLOTS-1:1] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o    <= '0;
      hash_lo_o <= '0;
      hash_hi_o <= '0;
      en_q      <= '0;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        ADDR_W'(0): mode_o    <= mode_t'(wr_data_i[MODE_W-1:0]);
        ADDR_W'(1): hash_lo_o <= wr_data_i;
        ADDR_W'(2): hash_hi_o <= wr_data_i;
        ADDR_W'(3): en_q      <= wr_data_i[NUM_SLOTS-1:1];
        default: ;
      endcase
    end
  end

  assign slot_en_o = {en_q, 1'b1};

  AST_MODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && wr_addr_i == ADDR_W'(0)) |=> $stable(mode_o)); // R1
endmodule

// File: rtl/rxf_perfect_bank.sv
module rxf_perfect_bank #(
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned NUM_SLOTS = 17,
  parameter int unsigned SLOT_BASE = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    wr_addr_i,
  input  logic [31:0]          wr_data_i,
  input  logic [NUM_SLOTS-1:0] slot_en_i,
  input  logic [47:0]          da_i,
  output logic                 hit_o
);
  logic [NUM_SLOTS-1:0] hit_vec;

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(SLOT_BASE + 2*k);
    localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(SLOT_BASE + 2*k + 1);
    logic [15:0] hi_q;
    logic [31:0] lo_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hi_q <= '0;
        lo_q <= '0;
      end else if (wr_en_i) begin
        if (wr_addr_i == HI_A) hi_q <= wr_data_i[15:0];
        if (wr_addr_i == LO_A) lo_q <= wr_data_i;
      end
    end

    assign hit_vec[k] = slot_en_i[k] && ({hi_q, lo_q} == da_i);
  end

  assign hit_o = |hit_vec;

  AST_SLOT0_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_en_i[0]); // R4
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxf_pkg::*;
#(
  parameter int unsigned NUM_EXTRA = 16,
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned SLOT_BASE = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [31:0]       wr_data_i,
  input  logic              sof_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_i,
  output logic              decision_valid_o,
  output logic              accept_o,
  output logic [2:0]        match_o
);
  localparam int unsigned NUM_SLOTS = NUM_EXTRA + 1;
  localparam int unsigned CNT_W     = $clog2(DA_BYTES + 1);

  mode_t                mode;
  logic [31:0]          hash_lo, hash_hi;
  logic [NUM_SLOTS-1:0] slot_en;
  logic [5:0]           hidx;
  logic                 perfect_hit;

  logic [CNT_W-1:0] cnt_q, cnt_base, cnt_d;
  logic [47:0]      da_q;
  logic             done_q, take;

  rxf_cfg_regs #(.ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS)) u_cfg (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .mode_o(mode), .hash_lo_o(hash_lo), .hash_hi_o(hash_hi), .slot_en_o(slot_en)
  );

  rxf_perfect_bank #(.ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS), .SLOT_BASE(SLOT_BASE)) u_bank (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .slot_en_i(slot_en), .da_i(da_q), .hit_o(perfect_hit)
  );

  rxf_crc8 u_crc (
    .clk_i, .rst_ni, .clr_i(sof_i), .en_i(take), .byte_i, .idx_o(hidx)
  );

  // byte capture
  assign cnt_base = sof_i ? '0 : cnt_q;
  assign take     = byte_valid_i && (cnt_base != CNT_W'(DA_BYTES));
  assign cnt_d    = cnt_base + CNT_W'(take);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      da_q   <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= take && (cnt_d == CNT_W'(DA_BYTES));
      if (take) da_q <= {da_q[39:0], byte_i};
    end
  end

  // verdict
  logic   is_mc, is_bc, hash_bit;
  match_e mt;

  assign is_mc    = da_q[40];
  assign is_bc    = &da_q;
  assign hash_bit = hidx[5] ? hash_hi[hidx[4:0]] : hash_lo[hidx[4:0]];

  always_comb begin
    mt = MT_NONE;
    if (mode.rx_all || mode.promisc)  mt = MT_PROMISC;
    else if (is_bc)                   mt = mode.bcast_dis ? MT_NONE : MT_BCAST;
    else if (is_mc) begin
      if (mode.pass_mc)               mt = MT_ALLMC;
      else if (mode.hash_mc && hash_bit) mt = MT_HASH;
    end else if (perfect_hit)         mt = MT_PERFECT;
  end

  assign decision_valid_o = done_q;
  assign match_o          = done_q ? mt : MT_NONE;
  assign accept_o         = done_q && (mt != MT_NONE);

  AST_PULSE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    decision_valid_o |=> !decision_valid_o); // R2
  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DA_BYTES)); // R2
  AST_ACCEPT_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    decision_valid_o |-> (accept_o == (match_o != 3'd0))); // R11
  AST_RXALL_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (decision_valid_o && mode.rx_all) |-> (accept_o && match_o == 3'd4)); // R9
  AST_PROMISC_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (decision_valid_o && mode.promisc) |-> accept_o); // R8
  AST_BCAST_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (decision_valid_o && (&da_q) && mode.bcast_dis && !mode.rx_all && !mode.promisc)
      |-> !accept_o); // R10
endmodule

// File: tb/sim_rx_addr_filter.sv
module sim_rx_addr_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        sof = 1'b0, bv = 1'b0;
  logic [7:0]  bt = '0;
  logic        dv, acc;
  logic [2:0]  mt;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rx_addr_filter u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .sof_i(sof), .byte_valid_i(bv), .byte_i(bt),
    .decision_valid_o(dv), .accept_o(acc), .match_o(mt)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic set_slot(input int k, input logic [47:0] a);
    wr(6'(16 + 2*k), {16'h0, a[47:32]});
    wr(6'(17 + 2*k), a[31:0]);
  endtask

  // bit-serial reference CRC, wire order, lsb first per byte
  function automatic logic [5:0] ref_idx(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    logic [31:0] r;
    for (int by = 0; by < 6; by++)
      for (int bi = 0; bi < 8; bi++) begin
        logic fb;
        fb = c[0] ^ a[47 - 8*by - 7 + bi];
        c = c >> 1;
        if (fb) c = c ^ 32'hEDB88320;
      end
    c = ~c;
    for (int i = 0; i < 32; i++) r[31-i] = c[i];
    return r[31:26];
  endfunction

  task automatic send(input logic [47:0] a);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); sof = (i == 0); bv = 1'b1; bt = a[47 - 8*i -: 8];
    end
    @(negedge clk); sof = 1'b0; bv = 1'b0;
  endtask

  // send then check verdict, then that the pulse ended
  task automatic expect_da(input string req, input logic [47:0] a,
                           input logic e_acc, input logic [2:0] e_mt);
    send(a);
    chk({req, " valid"}, 32'(dv), 32'd1);
    chk({req, " accept"}, 32'(acc), 32'(e_acc));
    chk({req, " match"}, 32'(mt), 32'(e_mt));
    @(negedge clk);
    chk("R2 pulse width", 32'(dv), 32'd0);
  endtask

  task automatic t_reset;
    chk("R1 valid after reset", 32'(dv), 32'd0);
    expect_da("R1 no slot set", 48'h0200_1122_3344, 1'b0, 3'd0);
    expect_da("R1 slot0 zero", 48'h0, 1'b1, 3'd1);
    expect_da("R1 mc no mode", 48'h0100_5e00_0001, 1'b0, 3'd0);
  endtask

  task automatic t_perfect;
    set_slot(0, 48'h0211_2233_4455);
    expect_da("R4 slot0", 48'h0211_2233_4455, 1'b1, 3'd1);
    set_slot(3, 48'h02aa_bbcc_dd03);
    expect_da("R4 slot3 disabled", 48'h02aa_bbcc_dd03, 1'b0, 3'd0);
    wr(6'd3, 32'h0001_0008);
    expect_da("R4 slot3 enabled", 48'h02aa_bbcc_dd03, 1'b1, 3'd1);
    set_slot(16, 48'h0a0b_0c0d_0e10);
    expect_da("R4 slot16", 48'h0a0b_0c0d_0e10, 1'b1, 3'd1);
    expect_da("R11 unicast miss", 48'h0a0b_0c0d_0e11, 1'b0, 3'd0);
    wr(6'd3, 32'h0);
    expect_da("R4 slot16 off", 48'h0a0b_0c0d_0e10, 1'b0, 3'd0);
  endtask

  task automatic t_hash(input logic [47:0] a);
    logic [5:0] ix = ref_idx(a);
    logic [63:0] tbl;
    wr(6'd0, 32'h4);
    tbl = ~(64'd1 << ix);
    wr(6'd1, tbl[31:0]); wr(6'd2, tbl[63:32]);
    expect_da("R6 hash bit clear", a, 1'b0, 3'd0);
    tbl = 64'd1 << ix;
    wr(6'd1, tbl[31:0]); wr(6'd2, tbl[63:32]);
    expect_da("R5 hash bit set", a, 1'b1, 3'd2);
    wr(6'd0, 32'h0);
    expect_da("R6 hash mode off", a, 1'b0, 3'd0);
  endtask

  task automatic t_modes;
    wr(6'd1, 32'h0); wr(6'd2, 32'h0);
    wr(6'd0, 32'h2);
    expect_da("R7 all multicast", 48'h3333_0000_0001, 1'b1, 3'd5);
    expect_da("R7 unicast unaffected", 48'h0200_0000_0099, 1'b0, 3'd0);
    expect_da("R10 bcast", 48'hFFFF_FFFF_FFFF, 1'b1, 3'd3);
    wr(6'd0, 32'h10);
    expect_da("R10 bcast disabled", 48'hFFFF_FFFF_FFFF, 1'b0, 3'd0);
    wr(6'd0, 32'h11);
    expect_da("R8 promisc bcast", 48'hFFFF_FFFF_FFFF, 1'b1, 3'd4);
    wr(6'd0, 32'h1);
    expect_da("R8 promisc unicast", 48'h0200_0000_0099, 1'b1, 3'd4);
    wr(6'd0, 32'h18);
    expect_da("R9 rx_all bcast", 48'hFFFF_FFFF_FFFF, 1'b1, 3'd4);
    expect_da("R9 rx_all mc", 48'h0100_5e7f_0001, 1'b1, 3'd4);
    wr(6'd0, 32'h0);
  endtask

  task automatic t_restart;
    int seen = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); sof = (i == 0); bv = 1'b1; bt = 8'h5a;
      seen += dv;
    end
    send(48'h0211_2233_4455);
    chk("R3 restart verdict", 32'(acc), 32'd1);
    chk("R3 restart match", 32'(mt), 32'd1);
    chk("R3 no early pulse", 32'(seen), 32'd0);
    // trailing bytes without sof
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); bv = 1'b1; bt = 8'hff;
      if (i > 0) seen += dv;
    end
    @(negedge clk); bv = 1'b0; seen += dv;
    chk("R2 trailing bytes ignored", 32'(seen), 32'd0);
    expect_da("R3 next frame", 48'h0200_0000_0099, 1'b0, 3'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_perfect();
    t_hash(48'h0100_5e00_0001);
    t_hash(48'h3333_0000_00fb);
    t_hash(48'h0100_5e7f_fffa);
    t_modes();
    t_restart();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule